// File: doc/BRIEF.md
# NOR Flash Device Mode and Reset Controller

This block is the control core of a behavioural NOR-style flash device. It samples active-low chip-enable, output-enable and write-enable pins on every clock. It decodes byte-wide commands written on the data bus. It runs word program and block erase as internally timed cycle counts against a small word store held in registers. It also decides when the data bus is driven and when it floats. A status byte reports ready, erase-suspended, erase-error and program-error conditions. While an operation runs, reads return this status byte instead of array data.

The active-low reset pin is both the block's asynchronous reset and the device reset pin. Asserting it kills any running operation. The word or block under work is then flagged invalid, and reads of it raise `data_invalid_o`. After reset is released, two independent wake-up counters hold off reads and writes for their own number of cycles. Deselecting the chip floats the bus, but a running operation keeps counting.

The block writes a word by ANDing the new data into the stored word, so programming can only clear bits. Erasing a block sets every word in it to all ones. Each block holds 2^BLK_W words.

Top module: `nor_dev_ctrl`

## Requirements
- R1: While rst_ni is low, data_oe_o is 0. After reset the device is in read-array mode, and reading status (command 0x70 on data bits 7:0) returns 0x0080.
- R2: With ce_ni high, data_oe_o is 0 whatever the level of oe_ni.
- R3: After rst_ni rises, data_oe_o stays 0 for RD_WAKE_CYC clock edges and rises after that.
- R4: A write on any of the first WR_WAKE_CYC edges after reset release is ignored. Later writes are accepted.
- R5: Program is command 0x40 followed by a data cycle at the target address. Status bit 7 reads 0 for exactly PROG_CYC edges after the data cycle and 1 afterwards. Any read in that window returns the status byte.
- R6: Program stores old AND new data. If the new data has a 1 where the result has a 0, status bit 4 is set.
- R7: Erase is command 0x20 followed by 0xD0 at any address of the block. After ERASE_CYC edges every word of that block reads 0xFFFF and other blocks are unchanged. Any byte other than 0xD0 in the second cycle sets status bit 5 and starts nothing.
- R8: Command 0xB0 during an erase suspends it. Status then reads 0xC0, the erase count freezes, and command 0xFF gives array reads. Command 0xD0 resumes the erase, which then completes.
- R9: While a program or erase is counting, every command other than 0xB0 is ignored, including a program setup.
- R10: Asserting rst_ni during a program or erase aborts it. Reads of the aborted word or block then show data_invalid_o = 1 until a later operation on it completes.
- R11: Raising ce_ni during an operation does not stop it; the operation completes on schedule.
- R12: Command 0x50 clears status bits 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous device reset |
| ce_ni | input | 1 | Active-low chip enable |
| oe_ni | input | 1 | Active-low output enable |
| we_ni | input | 1 | Active-low write enable, one write per low cycle |
| addr_i | input | ADDR_W | Word address |
| data_i | input | DATA_W | Write data; commands on bits 7:0 |
| data_o | output | DATA_W | Read data or status byte |
| data_oe_o | output | 1 | Bus drive enable; 0 means high impedance |
| data_invalid_o | output | 1 | Word being read was left undefined by an aborted operation |

## Verification
The assertions assume that writes come as single-cycle low pulses of we_ni, and that inputs change only away from the rising clock edge. They also assume reset is held low for at least one edge. Under these assumptions the engine never sees a start while busy, and a pending setup never coexists with a counting operation. The bench drives every pin on the falling edge through one task per bus cycle. It waits out both wake windows after each reset, except in the test that deliberately probes inside them.

// File: rtl/nor_dev_pkg.sv
package nor_dev_pkg;
  localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_RD_STATUS = 8'h70;
  localparam logic [7:0] CMD_PROG      = 8'h40;
  localparam logic [7:0] CMD_ERASE     = 8'h20;
  localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND   = 8'hB0;
  localparam logic [7:0] CMD_CLR_STS   = 8'h50;

  typedef enum logic {MODE_ARRAY, MODE_STATUS} rd_mode_e;
  typedef enum logic [1:0] {PEND_NONE, PEND_PROG, PEND_ERASE} pend_e;
  typedef enum logic {OP_PROG, OP_ERASE} op_kind_e;
endpackage

// File: rtl/nor_wake_timer.sv
module nor_wake_timer #(
  parameter int unsigned CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ok_o
);
  localparam int unsigned CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!ok_o) cnt_q <= cnt_q + 1'b1;
  end

  assign ok_o = (cnt_q == CW'(CYC));

  a_r3_ok_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |=> ok_o);
endmodule

// File: rtl/nor_op_engine.sv
module nor_op_engine import nor_dev_pkg::*; #(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PROG_CYC  = 8,
  parameter int unsigned ERASE_CYC = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_prog_i,
  input  logic              start_erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  output logic              busy_o,
  output logic              run_o,
  output logic              susp_o,
  output op_kind_e          kind_o,
  output logic              done_prog_o,
  output logic              done_erase_o,
  output logic [ADDR_W-1:0] tgt_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int unsigned MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  logic              busy_q, susp_q, done;
  op_kind_e          kind_q;
  logic [ADDR_W-1:0] tgt_q;
  logic [DATA_W-1:0] wd_q;
  logic [CW-1:0]     cnt_q, lim;

  assign lim  = (kind_q == OP_PROG) ? CW'(PROG_CYC - 1) : CW'(ERASE_CYC - 1);
  assign done = run_o && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      susp_q <= 1'b0;
      kind_q <= OP_PROG;
      tgt_q  <= '0;
      wd_q   <= '0;
      cnt_q  <= '0;
    end else if (start_prog_i || start_erase_i) begin
      busy_q <= 1'b1;
      susp_q <= 1'b0;
      kind_q <= start_erase_i ? OP_ERASE : OP_PROG;
      tgt_q  <= addr_i;
      wd_q   <= wdata_i;
      cnt_q  <= '0;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (suspend_i && run_o) begin
      susp_q <= 1'b1;
    end else if (resume_i && susp_q) begin
      susp_q <= 1'b0;
    end else if (run_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o       = busy_q;
  assign run_o        = busy_q && !susp_q;
  assign susp_o       = susp_q;
  assign kind_o       = kind_q;
  assign done_prog_o  = done && (kind_q == OP_PROG);
  assign done_erase_o = done && (kind_q == OP_ERASE);
  assign tgt_o        = tgt_q;
  assign wdata_o      = wd_q;

  a_r8_susp_only_erase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_q |-> (busy_q && kind_q == OP_ERASE));
  a_r8_count_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp_q && !resume_i) |=> $stable(cnt_q));
  a_r5_done_clears_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !busy_q);
  a_r5_target_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_prog_i && !start_erase_i) |=> $stable(tgt_q));
endmodule

// File: rtl/nor_word_array.sv
module nor_word_array #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BLK_W  = 3
) (
  input  logic              clk_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_inv_o,
  input  logic              mark_prog_i,
  input  logic              mark_erase_i,
  input  logic [ADDR_W-1:0] mark_addr_i,
  input  logic              commit_prog_i,
  input  logic              commit_erase_i,
  input  logic [ADDR_W-1:0] commit_addr_i,
  input  logic [DATA_W-1:0] commit_data_i
);
  localparam int unsigned WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [WORDS];
  logic [WORDS-1:0]  inv_q, mark_hit, prog_hit, erase_hit;

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_hit
    localparam logic [ADDR_W-1:0] IA = ADDR_W'(gi);
    assign mark_hit[gi]  = (mark_prog_i && mark_addr_i == IA) ||
                           (mark_erase_i && mark_addr_i[ADDR_W-1:BLK_W] == IA[ADDR_W-1:BLK_W]);
    assign prog_hit[gi]  = commit_prog_i && commit_addr_i == IA;
    assign erase_hit[gi] = commit_erase_i &&
                           commit_addr_i[ADDR_W-1:BLK_W] == IA[ADDR_W-1:BLK_W];
  end

  // storage is nonvolatile: no reset
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < WORDS; i++) begin
      if (erase_hit[i]) begin
        mem_q[i] <= '1;
        inv_q[i] <= 1'b0;
      end else if (prog_hit[i]) begin
        mem_q[i] <= mem_q[i] & commit_data_i;
        inv_q[i] <= 1'b0;
      end else if (mark_hit[i]) begin
        inv_q[i] <= 1'b1;
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign rd_inv_o  = inv_q[rd_addr_i];
endmodule

// File: rtl/nor_dev_ctrl.sv
module nor_dev_ctrl import nor_dev_pkg::*; #(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned BLK_W       = 3,
  parameter int unsigned PROG_CYC    = 8,
  parameter int unsigned ERASE_CYC   = 20,
  parameter int unsigned RD_WAKE_CYC = 4,
  parameter int unsigned WR_WAKE_CYC = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              data_invalid_o
);
  logic rd_ok, wr_ok;
  logic eng_busy, eng_run, eng_susp, done_prog, done_erase;
  op_kind_e          eng_kind;
  logic [ADDR_W-1:0] eng_tgt;
  logic [DATA_W-1:0] eng_wd, arr_rdata;
  logic              arr_inv;

  rd_mode_e mode_q;
  pend_e    pend_q;
  logic     perr_q, eerr_q;

  logic       wr, start_prog, start_erase, seq_err, susp_req, resume_req, prog_fail, show_sts;
  logic [7:0] cmd, sts;

  nor_wake_timer #(.CYC(RD_WAKE_CYC)) u_rd_wake (.clk_i, .rst_ni, .ok_o(rd_ok));
  nor_wake_timer #(.CYC(WR_WAKE_CYC)) u_wr_wake (.clk_i, .rst_ni, .ok_o(wr_ok));

  assign cmd         = data_i[7:0];
  assign wr          = !ce_ni && !we_ni && wr_ok;
  assign start_prog  = wr && !eng_busy && pend_q == PEND_PROG;
  assign start_erase = wr && !eng_busy && pend_q == PEND_ERASE && cmd == CMD_CONFIRM;
  assign seq_err     = wr && !eng_busy && pend_q == PEND_ERASE && cmd != CMD_CONFIRM;
  assign susp_req    = wr && eng_run && eng_kind == OP_ERASE && cmd == CMD_SUSPEND;
  assign resume_req  = wr && eng_susp && pend_q == PEND_NONE && cmd == CMD_CONFIRM;
  assign prog_fail   = start_prog && ((arr_rdata & data_i) != data_i);

  nor_op_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_engine (
    .clk_i, .rst_ni,
    .start_prog_i (start_prog),
    .start_erase_i(start_erase),
    .addr_i       (addr_i),
    .wdata_i      (data_i),
    .suspend_i    (susp_req),
    .resume_i     (resume_req),
    .busy_o       (eng_busy),
    .run_o        (eng_run),
    .susp_o       (eng_susp),
    .kind_o       (eng_kind),
    .done_prog_o  (done_prog),
    .done_erase_o (done_erase),
    .tgt_o        (eng_tgt),
    .wdata_o      (eng_wd)
  );

  nor_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_array (
    .clk_i,
    .rd_addr_i     (addr_i),
    .rd_data_o     (arr_rdata),
    .rd_inv_o      (arr_inv),
    .mark_prog_i   (start_prog),
    .mark_erase_i  (start_erase),
    .mark_addr_i   (addr_i),
    .commit_prog_i (done_prog),
    .commit_erase_i(done_erase),
    .commit_addr_i (eng_tgt),
    .commit_data_i (eng_wd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_ARRAY;
      pend_q <= PEND_NONE;
      perr_q <= 1'b0;
      eerr_q <= 1'b0;
    end else if (wr && !eng_run) begin
      if (pend_q != PEND_NONE) begin
        pend_q <= PEND_NONE;
        mode_q <= MODE_STATUS;
        if (prog_fail) perr_q <= 1'b1;
        if (seq_err)   eerr_q <= 1'b1;
      end else begin
        case (cmd)
          CMD_RD_ARRAY:  mode_q <= MODE_ARRAY;
          CMD_RD_STATUS: mode_q <= MODE_STATUS;
          CMD_PROG:      if (!eng_susp) pend_q <= PEND_PROG;
          CMD_ERASE:     if (!eng_susp) pend_q <= PEND_ERASE;
          CMD_CLR_STS: begin
            perr_q <= 1'b0;
            eerr_q <= 1'b0;
          end
          CMD_CONFIRM:   if (eng_susp) mode_q <= MODE_STATUS;
          default: ;
        endcase
      end
    end
  end

  assign sts            = {!eng_run, eng_susp, eerr_q, perr_q, 4'b0000};
  assign show_sts       = eng_run || mode_q == MODE_STATUS;
  assign data_o         = show_sts ? DATA_W'(sts) : arr_rdata;
  assign data_oe_o      = !ce_ni && !oe_ni && rd_ok;
  assign data_invalid_o = data_oe_o && !show_sts && arr_inv;

  always_comb begin
    if (!rst_ni) a_r1_hiz_in_reset: assert (!data_oe_o);
  end

  a_r9_no_pending_while_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_run |-> pend_q == PEND_NONE);
  a_r10_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_prog || start_erase) |=> eng_busy);
  a_r8_resume_only_suspended: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_req |=> !eng_susp);
endmodule

// File: tb/tb_nor_dev_ctrl.sv
`timescale 1ns/1ps
module tb_nor_dev_ctrl;
  localparam int AW = 5, DW = 16, PC = 8, EC = 20, RW = 4, WW = 10;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic          data_oe_o, data_invalid_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [DW-1:0] rd_d;
  logic          rd_oe, rd_inv;

  always #2.5 clk_i = ~clk_i;

  nor_dev_ctrl #(.ADDR_W(AW), .DATA_W(DW), .BLK_W(3), .PROG_CYC(PC), .ERASE_CYC(EC),
                 .RD_WAKE_CYC(RW), .WR_WAKE_CYC(WW)) dut (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni, .addr_i, .data_i,
    .data_o, .data_oe_o, .data_invalid_o);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_cycle(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk_i);
    ce_ni = 1'b0; oe_ni = 1'b1; we_ni = 1'b0; addr_i = a; data_i = d;
    @(negedge clk_i);
    we_ni = 1'b1; ce_ni = 1'b1;
  endtask

  task automatic rd_now(logic [AW-1:0] a);
    ce_ni = 1'b0; oe_ni = 1'b0; we_ni = 1'b1; addr_i = a;
    #1;
    rd_d = data_o; rd_oe = data_oe_o; rd_inv = data_invalid_o;
  endtask

  task automatic rd(logic [AW-1:0] a);
    @(negedge clk_i);
    rd_now(a);
  endtask

  task automatic idle(int n);
    @(negedge clk_i);
    ce_ni = 1'b1; oe_ni = 1'b1;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic erase_blk(logic [AW-1:0] a);
    wr_cycle(a, 16'h0020);
    wr_cycle(a, 16'h00D0);
    idle(EC + 2);
  endtask

  task automatic prog_word(logic [AW-1:0] a, logic [DW-1:0] d);
    wr_cycle(a, 16'h0040);
    wr_cycle(a, d);
    idle(PC + 2);
  endtask

  task automatic t_reset();
    ce_ni = 1'b0; oe_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R1 hiz in reset", data_oe_o, 0);
    ce_ni = 1'b1;
    rst_ni = 1'b1;
    idle(WW + 2);
    wr_cycle(0, 16'h0070);
    rd(0);
    chk("R1 status after reset", rd_d, 16'h0080);
  endtask

  task automatic t_standby_idle();
    @(negedge clk_i);
    ce_ni = 1'b1; oe_ni = 1'b0;
    #1;
    chk("R2 ce high floats bus", data_oe_o, 0);
  endtask

  task automatic t_program();
    erase_blk(0);
    wr_cycle(1, 16'h0040);
    wr_cycle(1, 16'h00FF);
    rd_now(1);
    chk("R5 busy status", rd_d, 16'h0000);
    repeat (PC - 1) @(posedge clk_i);
    @(negedge clk_i);
    rd_now(1);
    chk("R5 busy at last cycle", rd_d, 16'h0000);
    @(negedge clk_i);
    rd_now(1);
    chk("R5 ready after PROG_CYC", rd_d, 16'h0080);
    wr_cycle(0, 16'h00FF);
    rd(1);
    chk("R6 programmed word", rd_d, 16'h00FF);
    prog_word(1, 16'h0F0F);
    rd(1);
    chk("R6 program error bit", rd_d, 16'h0090);
    wr_cycle(0, 16'h00FF);
    rd(1);
    chk("R6 AND result", rd_d, 16'h000F);
    wr_cycle(0, 16'h0050);
    wr_cycle(0, 16'h0070);
    rd(0);
    chk("R12 clear status", rd_d, 16'h0080);
  endtask

  task automatic t_erase();
    erase_blk(8);
    prog_word(9, 16'h00F0);
    erase_blk(9);
    wr_cycle(0, 16'h00FF);
    rd(9);
    chk("R7 erased word", rd_d, 16'hFFFF);
    rd(15);
    chk("R7 erased block end", rd_d, 16'hFFFF);
    rd(1);
    chk("R7 other block kept", rd_d, 16'h000F);
    wr_cycle(0, 16'h0020);
    wr_cycle(0, 16'h00FF);
    rd(0);
    chk("R7 bad confirm error", rd_d, 16'h00A0);
    wr_cycle(0, 16'h00FF);
    rd(1);
    chk("R7 bad confirm no erase", rd_d, 16'h000F);
    wr_cycle(0, 16'h0050);
  endtask

  task automatic t_suspend();
    wr_cycle(16, 16'h0020);
    wr_cycle(16, 16'h00D0);
    idle(5);
    wr_cycle(16, 16'h00B0);
    rd(16);
    chk("R8 suspended status", rd_d, 16'h00C0);
    wr_cycle(0, 16'h00FF);
    rd(1);
    chk("R8 array read in suspend", rd_d, 16'h000F);
    idle(EC * 2);
    wr_cycle(0, 16'h0070);
    rd(0);
    chk("R8 erase frozen", rd_d, 16'h00C0);
    wr_cycle(16, 16'h00D0);
    rd_now(16);
    chk("R8 resumed busy", rd_d, 16'h0000);
    idle(EC + 2);
    rd(16);
    chk("R8 ready after resume", rd_d, 16'h0080);
    wr_cycle(0, 16'h00FF);
    rd(16);
    chk("R8 erase done data", rd_d, 16'hFFFF);
    chk("R8 erase done valid", rd_inv, 0);
  endtask

  task automatic t_ignore();
    wr_cycle(2, 16'h0040);
    wr_cycle(2, 16'h00AA);
    wr_cycle(1, 16'h0040);
    wr_cycle(1, 16'h00FF);
    idle(PC + 2);
    wr_cycle(1, 16'h0000);
    idle(PC + 2);
    rd(0);
    chk("R9 ready, nothing started", rd_d, 16'h0080);
    wr_cycle(0, 16'h00FF);
    rd(1);
    chk("R9 setup while busy ignored", rd_d, 16'h000F);
    rd(2);
    chk("R9 original program done", rd_d, 16'h00AA);
  endtask

  task automatic t_standby_op();
    wr_cycle(3, 16'h0040);
    wr_cycle(3, 16'h0055);
    @(negedge clk_i);
    ce_ni = 1'b1; oe_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R2 floats during op", data_oe_o, 0);
    repeat (PC + 2) @(negedge clk_i);
    wr_cycle(0, 16'h00FF);
    rd(3);
    chk("R11 op completed deselected", rd_d, 16'h0055);
  endtask

  task automatic t_wake();
    prog_word(5, 16'h1234);
    pulse_reset();
    ce_ni = 1'b0; oe_ni = 1'b0; addr_i = 5;
    repeat (RW - 1) @(posedge clk_i);
    @(negedge clk_i);
    chk("R3 still floating", data_oe_o, 0);
    @(negedge clk_i);
    chk("R3 driving after wake", data_oe_o, 1);
    wr_cycle(5, 16'h0070);
    rd(5);
    chk("R4 early write ignored", rd_d, 16'h1234);
    idle(WW);
    wr_cycle(5, 16'h0070);
    rd(5);
    chk("R4 write accepted later", rd_d, 16'h0080);
  endtask

  task automatic t_abort();
    wr_cycle(24, 16'h0020);
    wr_cycle(24, 16'h00D0);
    idle(5);
    pulse_reset();
    idle(WW + 2);
    wr_cycle(0, 16'h0070);
    rd(0);
    chk("R10 status after abort", rd_d, 16'h0080);
    wr_cycle(0, 16'h00FF);
    rd(27);
    chk("R10 aborted block invalid", rd_inv, 1);
    rd(1);
    chk("R10 other word valid", rd_inv, 0);
    wr_cycle(4, 16'h0040);
    wr_cycle(4, 16'h0011);
    idle(2);
    pulse_reset();
    idle(WW + 2);
    rd(4);
    chk("R10 aborted word invalid", rd_inv, 1);
    erase_blk(24);
    wr_cycle(0, 16'h00FF);
    rd(27);
    chk("R10 valid after re-erase", rd_inv, 0);
  endtask

  initial begin
    t_reset();
    t_standby_idle();
    t_program();
    t_erase();
    t_suspend();
    t_ignore();
    t_standby_op();
    t_wake();
    t_abort();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule